// File: doc/BRIEF.md
# Wave Memory Read-Pointer Sequencer

This block walks eight sample-playback voices through wave memory in a fixed round-robin schedule. Each voice owns a period of twelve slots, and the slot counter moves by one step on each clock enable. When the twelfth slot ends, the sequencer passes to the next voice, and after the last voice it returns to the first. For every voice it keeps a 27-bit read pointer with 11 fractional bits, a playback state of restart, running or loop, and the last sample byte it fetched.

In three fixed slots of a voice's period the block does real work. In one slot it reloads the pointer from the voice's start or loop register. In the next slot it reads one byte of wave memory at the pointer's integer part. Two slots later it advances the pointer by the voice's pitch step. The byte 0xFF is a loop marker and never becomes a sample. A host interface block outside this one supplies the register values, the global play flag, the per-voice mute bits and one-cycle restart requests. A mixer outside the block consumes the voice number, the slot number and the sample byte.

Top module: `wave_seq`

## Requirements
- R1: After reset, slotIdx and curChan are 0, every voice is in the restart state (code 0), and every pointer and held sample is 0.
- R2: slotIdx steps by one on each cycle with tickEn high and holds when tickEn is low. It runs 0 to 11, then returns to 0 while curChan steps by one modulo 8.
- R3: A voice does nothing on any slot unless soundOn is 1 and its bit in chMute is 0. While inactive, its pointer, state and sample stay unchanged.
- R4: In slot 1, an active voice in the restart state loads its pointer with its 8-bit start value placed in pointer bits 26:19, with lower bits zero, and enters the running state (code 1).
- R5: In slot 1, an active voice in the loop state (code 2) loads its pointer with its 16-bit loop value placed in pointer bits 26:11, with fraction zero, and enters the running state.
- R6: In slot 2, an active voice reads memData at memAddr. A byte of 0xFF puts the voice in the loop state and leaves its held sample unchanged. Any other byte becomes its held sample.
- R7: In slot 4, an active voice adds its 16-bit step value to the pointer, and the sum wraps modulo 2^27.
- R8: A high bit in startReq puts that voice in the restart state on that clock. This takes priority over any state change that the slot schedule makes on the same clock.
- R9: memAddr always equals bits 26:11 of the current voice's pointer. curPtr, curState and sampleOut always show the current voice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Slot step enable |
| soundOn | input | 1 | Global play flag |
| chMute | input | 8 | Per-voice disable bits |
| startReq | input | 8 | One-cycle restart request per voice |
| startVal | input | 64 | Start value, 8 bits per voice, voice i at bits 8i+7:8i |
| loopVal | input | 128 | Loop address, 16 bits per voice |
| stepVal | input | 128 | Pitch step, 16 bits per voice |
| memData | input | 8 | Wave memory read data, combinational from memAddr |
| memAddr | output | 16 | Wave memory read address |
| curChan | output | 3 | Voice currently served |
| slotIdx | output | 4 | Current slot within the voice period |
| curPtr | output | 27 | Current voice's pointer |
| curState | output | 2 | Current voice's state: 0 restart, 1 running, 2 loop |
| sampleOut | output | 8 | Current voice's held sample |

## Verification
If a voice's pointer is corrupted, the fault shows on memAddr and curPtr during that voice's next period, at most 96 slot steps later, and then stays there, because each later advance builds on the wrong value. If a voice's state is wrong, the slot 1 reload lands at the wrong address, or a loop marker is taken as a sample and shows on sampleOut. A slip in the slot or voice counters makes every voice that follows run its actions in the wrong slot, so the error appears within one slot step.

// File: rtl/wseq_pkg.sv
`timescale 1ns/1ps
package wseq_pkg;
  typedef enum logic [1:0] {
    CH_START = 2'd0,
    CH_RUN   = 2'd1,
    CH_LOOP  = 2'd2
  } chState_e;

  typedef struct packed {
    logic reload;
    logic fetch;
    logic advance;
  } slotStrobe_t;

  localparam int RELOAD_SLOT  = 1;
  localparam int FETCH_SLOT   = 2;
  localparam int ADVANCE_SLOT = 4;
  localparam logic [7:0] LOOP_MARK = 8'hFF;
endpackage

// File: rtl/wseq_ctrl.sv
`timescale 1ns/1ps
module wseq_ctrl
  import wseq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SLOTS  = 12,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickEn,
  input  logic              soundOn,
  input  logic [NUM_CH-1:0] chMute,
  output logic [CH_W-1:0]   curChan,
  output logic [SLOT_W-1:0] slotIdx,
  output slotStrobe_t       stb
);
  logic active;
  assign active = soundOn && !chMute[curChan];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slotIdx <= '0;
      curChan <= '0;
    end else if (tickEn) begin
      if (slotIdx == SLOT_W'(SLOTS - 1)) begin
        slotIdx <= '0;
        curChan <= (curChan == CH_W'(NUM_CH - 1)) ? '0 : curChan + 1'b1;
      end else begin
        slotIdx <= slotIdx + 1'b1;
      end
    end
  end

  always_comb begin
    stb.reload  = tickEn && active && (slotIdx == SLOT_W'(RELOAD_SLOT));
    stb.fetch   = tickEn && active && (slotIdx == SLOT_W'(FETCH_SLOT));
    stb.advance = tickEn && active && (slotIdx == SLOT_W'(ADVANCE_SLOT));
  end
endmodule

// File: rtl/wseq_path.sv
`timescale 1ns/1ps
module wseq_path
  import wseq_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int PTR_W   = 27,
  parameter int FRAC_W  = 11,
  parameter int START_W = 8,
  parameter int LOOP_W  = 16,
  parameter int STEP_W  = 16,
  parameter int DATA_W  = 8,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  slotStrobe_t               stb,
  input  logic [CH_W-1:0]           curChan,
  input  logic [NUM_CH-1:0]         startReq,
  input  logic [NUM_CH*START_W-1:0] startVal,
  input  logic [NUM_CH*LOOP_W-1:0]  loopVal,
  input  logic [NUM_CH*STEP_W-1:0]  stepVal,
  input  logic [DATA_W-1:0]         memData,
  output logic [PTR_W-1:0]          curPtr,
  output chState_e                  curState,
  output logic [DATA_W-1:0]         sampleOut
);
  logic [PTR_W-1:0]  ptrAll [NUM_CH];
  chState_e          stAll  [NUM_CH];
  logic [DATA_W-1:0] smpAll [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_voice
    logic              sel;
    logic [PTR_W-1:0]  ptr;
    chState_e          st;
    logic [DATA_W-1:0] smp;
    logic [START_W-1:0] stv;
    logic [LOOP_W-1:0]  lpv;
    logic [STEP_W-1:0]  spv;

    assign sel = (curChan == CH_W'(i));
    assign stv = startVal[i*START_W +: START_W];
    assign lpv = loopVal[i*LOOP_W +: LOOP_W];
    assign spv = stepVal[i*STEP_W +: STEP_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr <= '0;
        st  <= CH_START;
        smp <= '0;
      end else begin
        if (sel && stb.reload) begin
          if (st == CH_START) begin
            ptr <= {stv, {(PTR_W-START_W){1'b0}}};
            st  <= CH_RUN;
          end else if (st == CH_LOOP) begin
            ptr <= PTR_W'({lpv, {FRAC_W{1'b0}}});
            st  <= CH_RUN;
          end
        end
        if (sel && stb.fetch) begin
          if (memData == LOOP_MARK) st <= CH_LOOP;
          else                      smp <= memData;
        end
        if (sel && stb.advance) ptr <= ptr + PTR_W'(spv);
        if (startReq[i]) st <= CH_START;
      end
    end

    assign ptrAll[i] = ptr;
    assign stAll[i]  = st;
    assign smpAll[i] = smp;
  end

  assign curPtr    = ptrAll[curChan];
  assign curState  = stAll[curChan];
  assign sampleOut = smpAll[curChan];
endmodule

// File: rtl/wave_seq.sv
`timescale 1ns/1ps
module wave_seq
  import wseq_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int SLOTS   = 12,
  parameter int PTR_W   = 27,
  parameter int FRAC_W  = 11,
  parameter int START_W = 8,
  parameter int LOOP_W  = 16,
  parameter int STEP_W  = 16,
  parameter int DATA_W  = 8,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int ADDR_W = PTR_W - FRAC_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tickEn,
  input  logic                      soundOn,
  input  logic [NUM_CH-1:0]         chMute,
  input  logic [NUM_CH-1:0]         startReq,
  input  logic [NUM_CH*START_W-1:0] startVal,
  input  logic [NUM_CH*LOOP_W-1:0]  loopVal,
  input  logic [NUM_CH*STEP_W-1:0]  stepVal,
  input  logic [DATA_W-1:0]         memData,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [CH_W-1:0]           curChan,
  output logic [SLOT_W-1:0]         slotIdx,
  output logic [PTR_W-1:0]          curPtr,
  output logic [1:0]                curState,
  output logic [DATA_W-1:0]         sampleOut
);
  slotStrobe_t stb;
  chState_e    stNow;

  wseq_ctrl #(.NUM_CH(NUM_CH), .SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .soundOn(soundOn),
    .chMute(chMute), .curChan(curChan), .slotIdx(slotIdx), .stb(stb)
  );

  wseq_path #(
    .NUM_CH(NUM_CH), .PTR_W(PTR_W), .FRAC_W(FRAC_W), .START_W(START_W),
    .LOOP_W(LOOP_W), .STEP_W(STEP_W), .DATA_W(DATA_W)
  ) u_path (
    .clk(clk), .rst_n(rst_n), .stb(stb), .curChan(curChan),
    .startReq(startReq), .startVal(startVal), .loopVal(loopVal),
    .stepVal(stepVal), .memData(memData), .curPtr(curPtr),
    .curState(stNow), .sampleOut(sampleOut)
  );

  assign curState = stNow;
  assign memAddr  = curPtr[PTR_W-1:FRAC_W];
endmodule

// File: rtl/wseq_chk.sv
`timescale 1ns/1ps
module wseq_chk
  import wseq_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int SLOTS   = 12,
  parameter int PTR_W   = 27,
  parameter int FRAC_W  = 11,
  parameter int START_W = 8,
  parameter int LOOP_W  = 16,
  parameter int STEP_W  = 16,
  parameter int DATA_W  = 8,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int ADDR_W = PTR_W - FRAC_W
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tickEn,
  input logic                      soundOn,
  input logic [NUM_CH-1:0]         chMute,
  input logic [NUM_CH-1:0]         startReq,
  input logic [NUM_CH*START_W-1:0] startVal,
  input logic [NUM_CH*LOOP_W-1:0]  loopVal,
  input logic [NUM_CH*STEP_W-1:0]  stepVal,
  input logic [DATA_W-1:0]         memData,
  input logic [ADDR_W-1:0]         memAddr,
  input logic [CH_W-1:0]           curChan,
  input logic [SLOT_W-1:0]         slotIdx,
  input logic [PTR_W-1:0]          curPtr,
  input logic [1:0]                curState,
  input logic [DATA_W-1:0]         sampleOut
);
  logic [STEP_W-1:0] stepNow;
  logic activeNow, reqNow;
  assign stepNow   = stepVal[curChan*STEP_W +: STEP_W];
  assign activeNow = soundOn && !chMute[curChan];
  assign reqNow    = startReq[curChan];

  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tickEn |=> $stable(slotIdx) && $stable(curChan));
  // R2
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tickEn && slotIdx == SLOT_W'(SLOTS-1) |=>
      slotIdx == '0 && curChan == CH_W'($past(curChan) + 1'b1));
  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tickEn && slotIdx != SLOT_W'(SLOTS-1) |=>
      slotIdx == SLOT_W'($past(slotIdx) + 1'b1) && $stable(curChan));
  // R3
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tickEn && !activeNow && !reqNow && slotIdx != SLOT_W'(SLOTS-1) |=>
      $stable(curPtr) && $stable(curState) && $stable(sampleOut));
  // R4
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tickEn && activeNow && !reqNow && slotIdx == SLOT_W'(RELOAD_SLOT) && curState == 2'd0 |=>
      curState == 2'd1 && curPtr[PTR_W-START_W-1:0] == '0);
  // R5
  loop_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tickEn && activeNow && !reqNow && slotIdx == SLOT_W'(RELOAD_SLOT) && curState == 2'd2 |=>
      curState == 2'd1 && curPtr[FRAC_W-1:0] == '0);
  // R6
  marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tickEn && activeNow && !reqNow && slotIdx == SLOT_W'(FETCH_SLOT) && memData == LOOP_MARK |=>
      curState == 2'd2 && $stable(sampleOut));
  // R6
  sample_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tickEn && activeNow && slotIdx == SLOT_W'(FETCH_SLOT) && memData != LOOP_MARK |=>
      sampleOut == $past(memData));
  // R7
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tickEn && activeNow && slotIdx == SLOT_W'(ADVANCE_SLOT) |=>
      curPtr == PTR_W'($past(curPtr) + PTR_W'($past(stepNow))));
  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqNow && (!tickEn || slotIdx != SLOT_W'(SLOTS-1)) |=> curState == 2'd0);
endmodule

bind wave_seq wseq_chk #(
  .NUM_CH(NUM_CH), .SLOTS(SLOTS), .PTR_W(PTR_W), .FRAC_W(FRAC_W),
  .START_W(START_W), .LOOP_W(LOOP_W), .STEP_W(STEP_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/wave_seq_test.sv
`timescale 1ns/1ps
module wave_seq_test;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tickEn = 1'b0;
  logic soundOn = 1'b0;
  logic [NCH-1:0] chMute = '0;
  logic [NCH-1:0] startReq = '0;
  logic [NCH*8-1:0]  startVal = '0;
  logic [NCH*16-1:0] loopVal = '0;
  logic [NCH*16-1:0] stepVal = '0;
  logic [7:0]  memData;
  logic [15:0] memAddr;
  logic [2:0]  curChan;
  logic [3:0]  slotIdx;
  logic [26:0] curPtr;
  logic [1:0]  curState;
  logic [7:0]  sampleOut;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  logic [26:0] mPtr [NCH];
  logic [1:0]  mSt  [NCH];
  logic [7:0]  mSmp [NCH];
  int mSlot = 0;
  int mChan = 0;

  always #2 clk = ~clk;

  wave_seq uut (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .soundOn(soundOn),
    .chMute(chMute), .startReq(startReq), .startVal(startVal),
    .loopVal(loopVal), .stepVal(stepVal), .memData(memData),
    .memAddr(memAddr), .curChan(curChan), .slotIdx(slotIdx),
    .curPtr(curPtr), .curState(curState), .sampleOut(sampleOut)
  );

  function automatic logic [7:0] memFn(input logic [15:0] a);
    logic [7:0] v;
    if (a[7:0] == 8'h00 && a[8]) return 8'hFF;
    v = a[7:0] ^ a[15:8] ^ 8'h5A;
    if (v == 8'hFF) v = 8'h00;
    return v;
  endfunction

  always_comb memData = memFn(memAddr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: got %0h expected %0h (chan %0d slot %0d)", tag, act, exp, mChan, mSlot);
    end
  endtask

  task automatic compareAll(input string ptrTag, input string stTag);
    chk("R2 slot", 32'(slotIdx), 32'(mSlot));
    chk("R2 chan", 32'(curChan), 32'(mChan));
    chk(ptrTag, 32'(curPtr), 32'(mPtr[mChan]));
    chk(stTag, 32'(curState), 32'(mSt[mChan]));
    chk("R6 sample", 32'(sampleOut), 32'(mSmp[mChan]));
    chk("R9 addr", 32'(memAddr), 32'(curPtr[26:11]));
  endtask

  task automatic tick(input logic [NCH-1:0] req);
    int c;
    int s;
    logic act;
    logic [7:0] b;
    string ptrTag;
    c = mChan;
    s = mSlot;
    ptrTag = "R7 ptr";
    @(negedge clk);
    tickEn = 1'b1;
    startReq = req;
    act = soundOn && !chMute[c];
    if (act && s == 1) begin
      if (mSt[c] == 2'd0) begin
        mPtr[c] = {startVal[c*8 +: 8], 19'b0};
        mSt[c] = 2'd1;
        ptrTag = "R4 ptr";
      end else if (mSt[c] == 2'd2) begin
        mPtr[c] = {loopVal[c*16 +: 16], 11'b0};
        mSt[c] = 2'd1;
        ptrTag = "R5 ptr";
      end
    end
    if (act && s == 2) begin
      b = memFn(mPtr[c][26:11]);
      if (b == 8'hFF) mSt[c] = 2'd2;
      else mSmp[c] = b;
    end
    if (act && s == 4) mPtr[c] = mPtr[c] + 27'(stepVal[c*16 +: 16]);
    for (int i = 0; i < NCH; i++) if (req[i]) mSt[i] = 2'd0;
    if (s == 11) begin
      mSlot = 0;
      mChan = (c + 1) % NCH;
    end else begin
      mSlot = s + 1;
    end
    @(posedge clk);
    #1;
    tickEn = 1'b0;
    startReq = '0;
    compareAll(ptrTag, (req != '0) ? "R8 state" : "R6 state");
  endtask

  task automatic idleRound(input logic snd, input logic [NCH-1:0] mute);
    logic [26:0] p;
    logic [1:0] st;
    logic [7:0] sm;
    p = curPtr;
    st = curState;
    sm = sampleOut;
    soundOn = snd;
    chMute = mute;
    for (int k = 0; k < 96; k++) tick('0);
    chk("R3 ptr kept", 32'(curPtr), 32'(p));
    chk("R3 state kept", 32'(curState), 32'(st));
    chk("R3 sample kept", 32'(sampleOut), 32'(sm));
    soundOn = 1'b1;
    chMute = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < NCH; i++) begin
      mPtr[i] = '0;
      mSt[i] = 2'd0;
      mSmp[i] = '0;
      startVal[i*8 +: 8] = 8'($urandom);
      loopVal[i*16 +: 16] = 16'($urandom);
      stepVal[i*16 +: 16] = 16'($urandom) & 16'h3FFF;
    end
    startVal[7:0] = 8'h01;
    loopVal[15:0] = 16'h0203;
    stepVal[15:0] = 16'h0800;
    startVal[7*8 +: 8] = 8'hFF;
    loopVal[7*16 +: 16] = 16'hFFF0;
    stepVal[7*16 +: 16] = 16'hFFFF;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 slot", 32'(slotIdx), 32'd0);
    chk("R1 chan", 32'(curChan), 32'd0);
    chk("R1 ptr", 32'(curPtr), 32'd0);
    chk("R1 state", 32'(curState), 32'd0);
    chk("R1 sample", 32'(sampleOut), 32'd0);
    chk("R9 addr", 32'(memAddr), 32'd0);

    soundOn = 1'b1;
    // R2 no enable, no movement
    repeat (10) @(negedge clk);
    chk("R2 hold slot", 32'(slotIdx), 32'd0);
    chk("R2 hold chan", 32'(curChan), 32'd0);

    tick('0);
    tick('0);
    chk("R4 start load", 32'(curPtr), 32'h0100 << 11);
    chk("R4 running", 32'(curState), 32'd1);
    tick('0);
    chk("R6 marker to loop", 32'(curState), 32'd2);
    chk("R6 sample kept", 32'(sampleOut), 32'd0);
    for (int k = 0; k < 95; k++) tick('0);
    chk("R5 loop load", 32'(curPtr), 32'h0203 << 11);
    chk("R5 running", 32'(curState), 32'd1);
    tick(8'h01);
    for (int k = 0; k < 95; k++) tick('0);
    chk("R4 restart addr", 32'(memAddr), 32'h0100);
    tick(8'h01);
    chk("R8 restart wins over marker", 32'(curState), 32'd0);

    idleRound(1'b0, '0);
    idleRound(1'b1, '1);

    for (int n = 0; n < 4000; n++) begin
      if (n % 400 == 0) begin
        chMute = ($urandom % 4 == 0) ? NCH'($urandom) : '0;
        soundOn = ($urandom % 10 != 0);
      end
      if ($urandom % 8 == 0) repeat ($urandom % 3) @(negedge clk);
      tick(($urandom % 48 == 0) ? NCH'(1 << ($urandom % NCH)) : '0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule